// File: doc/BRIEF.md
# Configurable Interrupt Output Conditioner

This block turns an internal interrupt event into two outward signals: a general interrupt line and a system-management interrupt line. One configuration bit picks the polarity pair. With the bit clear the general line is active high and the management line active low, and setting it inverts both. A second bit chooses how the event is shown. In level mode the lines stay asserted until software clears the pending event. In pulse mode every accepted event gives one pulse of fixed length, longer than 100 us at a 125 MHz clock.

An 8-bit configuration register holds these two bits and three pin-function fields. It is reached through a plain write-enable, write-data and read-data port. A small multiplexer uses the fields to drive three shared pins. Each pin can carry general I/O data, an LED drive or an active-low watchdog signal, and one of them can also carry the general interrupt line. Those other functions are built elsewhere and arrive here only as input signals.

Top module: `irq_cond`

## Requirements
- R1: The configuration register holds 0x00 after reset. Bit 7 always reads 0, whatever value is written to it.
- R2: Bit 6 is the polarity bit. At 0 the inactive levels are irq_o=0 and smi_o=1. At 1 the inactive levels are irq_o=1 and smi_o=0. The active level of each line is the inverse of its inactive level.
- R3: With bit 5 = 0 (level mode), an event sampled at a clock edge makes both lines active from that edge on. They stay active until evt_clr_i is sampled with no event in the same cycle, so an event wins over a clear.
- R4: With bit 5 = 1 (pulse mode), an event sampled at an edge while no pulse is running starts a pulse that is active for exactly PULSE_CYC clock cycles. The default of 13000 cycles is 104 us at 125 MHz.
- R5: In pulse mode, events that arrive while a pulse runs, including in its last cycle, neither lengthen it nor start a new one. evt_clr_i has no effect in this mode.
- R6: A write that changes bit 6 or bit 5 forces both lines to their inactive levels (under the new polarity) from that edge on. An event sampled in the same cycle is dropped.
- R7: Pin A follows bits 4:3: 00 gives a_gpio_i, 01 gives a_led_i, 10 gives irq_o, and 11 gives wdog_n_i.
- R8: Pin B follows bits 1:0: 00 gives b_gpio_i, 01 gives b_led_i, and 10 or 11 gives wdog_n_i.
- R9: Pin C follows bit 2: 0 gives c_gpio_i and 1 gives c_led_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| evt_i | input | 1 | Interrupt event, sampled each cycle |
| evt_clr_i | input | 1 | Clears a pending level-mode event |
| a_gpio_i | input | 1 | General I/O data for pin A |
| a_led_i | input | 1 | LED drive for pin A |
| b_gpio_i | input | 1 | General I/O data for pin B |
| b_led_i | input | 1 | LED drive for pin B |
| c_gpio_i | input | 1 | General I/O data for pin C |
| c_led_i | input | 1 | LED drive for pin C |
| wdog_n_i | input | 1 | Active-low watchdog output |
| irq_o | output | 1 | General interrupt line |
| smi_o | output | 1 | System-management interrupt line |
| pin_a_o | output | 1 | Shared pin A |
| pin_b_o | output | 1 | Shared pin B |
| pin_c_o | output | 1 | Shared pin C |

## Verification
The bench measures the exact pulse length. It injects extra events in the middle of a pulse and in its last cycle, and it pulses the clear input during a pulse. A design that restarts or extends on a repeat event, or that ends early on a clear, gives a pulse that is too long or too short. It raises an event and a clear together and changes the polarity or mode bit while an event is pending. A design that lets the clear win loses that event, and one that does not flush its state shows a stale assertion under the new setting. It walks every pin-select code with the inputs in all eight combinations, so a swapped code or a wrong source appears on the pin.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    typedef enum logic [1:0] {
        PA_GPIO = 2'b00,
        PA_LED  = 2'b01,
        PA_IRQ  = 2'b10,
        PA_WDOG = 2'b11
    } pa_sel_e;

    // Field order matches register bits 6..0
    typedef struct packed {
        logic       pol;     // bit 6
        logic       pulse;   // bit 5
        pa_sel_e    pa_sel;  // bits 4:3
        logic       pc_sel;  // bit 2
        logic [1:0] pb_sel;  // bits 1:0
    } cfg_t;

    localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/irq_cond_cfg.sv
module irq_cond_cfg
    import irq_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    output cfg_t       cfg_o,
    output logic       chg_o,
    output logic [7:0] rdata_o
);

    cfg_t cfg_d, cfg_q;
    cfg_t wr_val;

    always_comb begin
        wr_val = cfg_t'(wdata_i[CFG_W-1:0]);
        cfg_d  = cfg_q;
        chg_o  = 1'b0;
        if (we_i) begin
            cfg_d = wr_val;
            chg_o = (wr_val.pol != cfg_q.pol) || (wr_val.pulse != cfg_q.pulse);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o   = cfg_q;
    assign rdata_o = {1'b0, cfg_q};

endmodule

// File: rtl/irq_cond_core.sv
module irq_cond_core #(
    parameter int unsigned PULSE_CYC = 13000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic chg_i,
    input  logic pulse_mode_i,
    input  logic pol_i,
    output logic irq_o,
    output logic smi_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic act;

    always_comb begin
        st_d = st_q;
        if (chg_i) begin
            st_d = '0;
        end else if (!pulse_mode_i) begin
            st_d.cnt = '0;
            if (evt_i)      st_d.pend = 1'b1;
            else if (clr_i) st_d.pend = 1'b0;
        end else begin
            st_d.pend = 1'b0;
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            else if (evt_i)     st_d.cnt = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act   = pulse_mode_i ? (st_q.cnt != '0) : st_q.pend;
    assign irq_o = act ^ pol_i;
    assign smi_o = ~(act ^ pol_i);

endmodule

// File: rtl/irq_cond_pinmux.sv
module irq_cond_pinmux
    import irq_cond_pkg::*;
(
    input  cfg_t cfg_i,
    input  logic irq_i,
    input  logic a_gpio_i,
    input  logic a_led_i,
    input  logic b_gpio_i,
    input  logic b_led_i,
    input  logic c_gpio_i,
    input  logic c_led_i,
    input  logic wdog_n_i,
    output logic pin_a_o,
    output logic pin_b_o,
    output logic pin_c_o
);

    always_comb begin
        unique case (cfg_i.pa_sel)
            PA_GPIO: pin_a_o = a_gpio_i;
            PA_LED:  pin_a_o = a_led_i;
            PA_IRQ:  pin_a_o = irq_i;
            default: pin_a_o = wdog_n_i;
        endcase
        if (cfg_i.pb_sel[1])      pin_b_o = wdog_n_i;
        else if (cfg_i.pb_sel[0]) pin_b_o = b_led_i;
        else                      pin_b_o = b_gpio_i;
        pin_c_o = cfg_i.pc_sel ? c_led_i : c_gpio_i;
    end

endmodule

// File: rtl/irq_cond.sv
module irq_cond
    import irq_cond_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 13000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       evt_i,
    input  logic       evt_clr_i,
    input  logic       a_gpio_i,
    input  logic       a_led_i,
    input  logic       b_gpio_i,
    input  logic       b_led_i,
    input  logic       c_gpio_i,
    input  logic       c_led_i,
    input  logic       wdog_n_i,
    output logic       irq_o,
    output logic       smi_o,
    output logic       pin_a_o,
    output logic       pin_b_o,
    output logic       pin_c_o
);

    cfg_t cfg;
    logic chg;

    irq_cond_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg),
        .chg_o   (chg),
        .rdata_o (cfg_rdata)
    );

    irq_cond_core #(.PULSE_CYC(PULSE_CYC)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .clr_i        (evt_clr_i),
        .chg_i        (chg),
        .pulse_mode_i (cfg.pulse),
        .pol_i        (cfg.pol),
        .irq_o        (irq_o),
        .smi_o        (smi_o)
    );

    irq_cond_pinmux u_mux (
        .cfg_i    (cfg),
        .irq_i    (irq_o),
        .a_gpio_i (a_gpio_i),
        .a_led_i  (a_led_i),
        .b_gpio_i (b_gpio_i),
        .b_led_i  (b_led_i),
        .c_gpio_i (c_gpio_i),
        .c_led_i  (c_led_i),
        .wdog_n_i (wdog_n_i),
        .pin_a_o  (pin_a_o),
        .pin_b_o  (pin_b_o),
        .pin_c_o  (pin_c_o)
    );

endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk #(
    parameter int unsigned PULSE_CYC = 13000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       evt_i,
    input logic       evt_clr_i,
    input logic       c_led_i,
    input logic       wdog_n_i,
    input logic       irq_o,
    input logic       smi_o,
    input logic       pin_a_o,
    input logic       pin_b_o,
    input logic       pin_c_o
);

    logic        act;
    int unsigned wcnt_q;

    assign act = irq_o ^ cfg_rdata[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   wcnt_q <= 0;
        else if (act) wcnt_q <= wcnt_q + 1;
        else          wcnt_q <= 0;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0); // R1

    AST_CFG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_wdata[6:5] != cfg_rdata[6:5]))
        |=> (irq_o == cfg_rdata[6] && smi_o != cfg_rdata[6])); // R6

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[5] && evt_i && !cfg_we) |=> act); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[5] && act && !evt_clr_i && !cfg_we) |=> act); // R3

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[5] && $fell(act) && !$past(cfg_we)) |-> (wcnt_q == PULSE_CYC)); // R4

    AST_PINA_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[4:3] == 2'b10) |-> (pin_a_o == irq_o)); // R7

    AST_PINB_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |-> (pin_b_o == wdog_n_i)); // R8

    AST_PINC_LED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2] |-> (pin_c_o == c_led_i)); // R9

endmodule

bind irq_cond irq_cond_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .evt_i     (evt_i),
    .evt_clr_i (evt_clr_i),
    .c_led_i   (c_led_i),
    .wdog_n_i  (wdog_n_i),
    .irq_o     (irq_o),
    .smi_o     (smi_o),
    .pin_a_o   (pin_a_o),
    .pin_b_o   (pin_b_o),
    .pin_c_o   (pin_c_o)
);

// File: tb/irq_cond_test.sv
module irq_cond_test;

    localparam int unsigned PC = 13000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       evt_i = 1'b0, evt_clr_i = 1'b0;
    logic       a_gpio_i = 1'b0, a_led_i = 1'b0, b_gpio_i = 1'b0, b_led_i = 1'b0;
    logic       c_gpio_i = 1'b0, c_led_i = 1'b0, wdog_n_i = 1'b1;
    logic       irq_o, smi_o, pin_a_o, pin_b_o, pin_c_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic pol = 1'b0;

    always #4 clk = ~clk;

    irq_cond #(.PULSE_CYC(PC)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic active();
        return irq_o ^ pol;
    endfunction

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        pol = v[6];
    endtask

    task automatic idle_check(input string req);
        chk(irq_o == pol, {req, " irq idle"}, irq_o, pol);
        chk(smi_o == !pol, {req, " smi idle"}, smi_o, !pol);
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
        idle_check("R2 reset");
        wr(8'hFF);
        chk(cfg_rdata == 8'h7F, "R1 bit7 reads zero", cfg_rdata, 8'h7F);
        wr(8'h00);
        chk(cfg_rdata == 8'h00, "R1 write back", cfg_rdata, 0);
    endtask

    task automatic t_level(input logic p);
        wr({1'b0, p, 6'b0});
        idle_check("R2 level");
        evt_i = 1'b1; @(negedge clk); evt_i = 1'b0;
        chk(irq_o == !p && smi_o == p, "R2 R3 asserted", {irq_o, smi_o}, {!p, p});
        repeat (20) @(negedge clk);
        chk(active() == 1'b1, "R3 held", active(), 1);
        evt_i = 1'b1; evt_clr_i = 1'b1; @(negedge clk);
        evt_i = 1'b0;
        chk(active() == 1'b1, "R3 event beats clear", active(), 1);
        @(negedge clk); evt_clr_i = 1'b0;
        chk(active() == 1'b0, "R3 cleared", active(), 0);
        idle_check("R3 after clear");
    endtask

    task automatic t_pulse(input logic p, input bit inject);
        int n;
        wr({1'b0, p, 1'b1, 5'b0});
        idle_check("R2 pulse idle");
        evt_i = 1'b1; @(negedge clk); evt_i = 1'b0;
        n = 0;
        while (active() && n < 20000) begin
            n++;
            evt_i     = inject && (n == 50 || n == PC);
            evt_clr_i = inject && (n == 77);
            @(negedge clk);
        end
        evt_i = 1'b0; evt_clr_i = 1'b0;
        if (inject) chk(n == PC, "R5 merged width", n, PC);
        else        chk(n == PC, "R4 pulse width", n, PC);
        repeat (3) @(negedge clk);
        chk(active() == 1'b0, "R5 no retrigger", active(), 0);
    endtask

    task automatic t_cfg_change;
        wr(8'h00);
        evt_i = 1'b1; @(negedge clk); evt_i = 1'b0;
        chk(active() == 1'b1, "R6 pending", active(), 1);
        wr(8'h40);
        idle_check("R6 polarity change drops");
        evt_i = 1'b1; @(negedge clk); evt_i = 1'b0;
        chk(active() == 1'b1, "R6 reassert", active(), 1);
        evt_i = 1'b1; wr(8'h60); evt_i = 1'b0;
        idle_check("R6 mode change drops event");
        repeat (3) @(negedge clk);
        chk(active() == 1'b0, "R6 event in write cycle dropped", active(), 0);
        wr(8'h00);
    endtask

    task automatic t_mux;
        for (int code = 0; code < 4; code++) begin
            for (int pat = 0; pat < 8; pat++) begin
                logic ea, eb, ec;
                wr({1'b0, pat[0], 1'b0, code[1:0], code[0], code[1:0]});
                a_gpio_i = pat[1]; a_led_i = pat[2]; wdog_n_i = pat[0] ^ pat[2];
                b_gpio_i = pat[2]; b_led_i = pat[1];
                c_gpio_i = pat[1]; c_led_i = !pat[1];
                #1;
                case (code)
                    0: ea = a_gpio_i;
                    1: ea = a_led_i;
                    2: ea = pat[0];
                    default: ea = wdog_n_i;
                endcase
                eb = code[1] ? wdog_n_i : (code[0] ? b_led_i : b_gpio_i);
                ec = code[0] ? c_led_i : c_gpio_i;
                chk(pin_a_o == ea, "R7 pin A", pin_a_o, ea);
                chk(pin_b_o == eb, "R8 pin B", pin_b_o, eb);
                chk(pin_c_o == ec, "R9 pin C", pin_c_o, ec);
            end
        end
        wr(8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level(1'b0);
        t_level(1'b1);
        t_pulse(1'b0, 1'b0);
        t_pulse(1'b1, 1'b1);
        t_cfg_change();
        t_mux();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule